// File: doc/BRIEF.md
# Approximate Logarithmic Multiplier and Divider

This block forms an approximate product or quotient of two unsigned operands without a multiplier array or a divider. Each operand is turned into a binary logarithm made of an integer characteristic (the index of its highest set bit) and a fixed-point fraction (the bits below that leading one). In multiply mode the two logarithms are added; in divide mode the second is subtracted from the first. The combined logarithm is then turned back into a binary number by an antilog shifter. The shifter places a leading one at the position given by the combined exponent and fills the bits below it with the combined fraction.

The datapath has one adder and one subtractor on the fractions and one exponent unit on the characteristics. A mode input selects between them. The carry out of the fraction adder moves into the exponent only when multiplying. The borrow out of the fraction subtractor lowers the exponent by one when dividing. Results are approximate: a product is never above the exact value and never below about eight ninths of it. An operand that is a power of two gives an exact result. The block is fully pipelined, accepts one operation per cycle, and returns each result with a one-cycle done pulse a fixed three cycles after its start strobe.

Top module: `approx_logmuldiv`

## Requirements
- R1: While reset is asserted and after its release, until the first done pulse, `done_o`, `dz_o` and `result_o` are all zero.
- R2: With `div_i`=0 and both operands nonzero, let k be the index of an operand's highest set bit and f=(x−2^k)·2^(W−1−k) its W−1 bit fraction. Let s=fa+fb and e=ka+kb. Then `result_o` = floor((2^(W−1)+s')·2^e' / 2^(W−1)), where s'=s and e'=e if s<2^(W−1), and otherwise s'=s−2^(W−1) and e'=e+1.
- R3: The fraction carry raises the exponent only in multiply mode. In divide mode a sum fa+fb ≥ 2^(W−1) has no effect on the exponent (for example 7/5 gives 0x18000 and not 0x30000).
- R4: With `div_i`=1 and both operands nonzero, let d=fa−fb and e=ka−kb. If d<0, the exponent becomes e−1 and the fraction becomes 2^(W−1)+d, which is 1+m1−m2; otherwise both are used as they are.
- R5: In divide mode `result_o` is a fixed-point quotient with W integer and W fractional bits, equal to (2^(W−1)+fraction) shifted left by e+1, or shifted right by −(e+1) when e+1<0, with the low bits truncated.
- R6: A zero operand in multiply mode, or a zero dividend with a nonzero divisor in divide mode, gives `result_o`=0 with `dz_o`=0.
- R7: In divide mode a zero divisor gives `dz_o`=1 and `result_o`=0. Every done pulse updates `dz_o`, so a later operation without a zero divisor clears it.
- R8: When the second operand is 2^j, the result is exact: a·2^j in multiply mode and a·2^(W−j) (that is, a/2^j in the quotient format) in divide mode.
- R9: For nonzero operands in multiply mode, `result_o` ≤ a·b and 9·`result_o`+9 ≥ 8·a·b.
- R10: `done_o` is high for exactly one cycle, three clock cycles after each cycle with `start_i` high. Starts on consecutive cycles give done pulses on consecutive cycles, each carrying its own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Operation strobe; operands and mode are sampled in this cycle |
| div_i | input | 1 | Mode: 0 multiply (logs added), 1 divide (logs subtracted) |
| opa_i | input | W (16) | Multiplicand or dividend, unsigned |
| opb_i | input | W (16) | Multiplier or divisor, unsigned |
| result_o | output | 2W (32) | Product, or quotient with W integer and W fraction bits |
| done_o | output | 1 | One-cycle pulse when `result_o` and `dz_o` hold a new result |
| dz_o | output | 1 | Divide-by-zero flag of the last completed operation |

## Verification
Most internal faults in this block show up three cycles after the start that triggered them, on the one done pulse that carries the result. A wrong leading-one index scales the result by a power of two. A carry or borrow that is dropped, or that leaks into the wrong mode, doubles or halves the result. A fraction bit that is wrong gives an error in the bits just below the leading one. A fault in the valid pipeline shows up as a missing done pulse, an extra one, or one in the wrong cycle, on the very next expected done. A reduced configuration with W=6 is swept over every operand pair in both modes against the arithmetic model, and the 16-bit default is checked on chosen corners.

// File: rtl/ald_pkg.sv
package ald_pkg;
  // Clock cycles from a sampled start strobe to its done pulse.
  localparam int unsigned LATENCY = 3;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } op_e;
endpackage

// File: rtl/ald_rst_sync.sv
module ald_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain[STAGES-1];
endmodule

// File: rtl/ald_log_conv.sv
module ald_log_conv #(
  parameter int W  = 16,
  parameter int EW = $clog2(W)
) (
  input  logic [W-1:0]  x_i,
  output logic [EW-1:0] k_o,
  output logic [W-2:0]  frac_o,
  output logic          zero_o
);
  logic [W-1:0] norm;

  // Leading-one index, then shift the operand so that one lands on the top bit.
  always_comb begin
    k_o = '0;
    for (int i = 0; i < W; i++) begin
      if (x_i[i]) k_o = EW'(i);
    end
    norm   = x_i << (EW'(W - 1) - k_o);
    frac_o = norm[W-2:0];
    zero_o = (x_i == '0);
  end

  // R2: the normalised operand has its leading one on top and loses no bit.
  always_comb begin
    if (x_i != '0) begin
      p_norm_top_r2: assert (norm[W-1])
        else $error("normalised operand lacks leading one");
      p_norm_lossless_r2: assert ((norm >> (EW'(W - 1) - k_o)) == x_i)
        else $error("normalisation dropped operand bits");
    end
  end
endmodule

// File: rtl/ald_combine.sv
module ald_combine #(
  parameter int W  = 16,
  parameter int EW = $clog2(W)
) (
  input  logic                 div_i,
  input  logic [EW-1:0]        ka_i,
  input  logic [W-2:0]         fa_i,
  input  logic [EW-1:0]        kb_i,
  input  logic [W-2:0]         fb_i,
  output logic signed [EW+1:0] exp_o,
  output logic [W-2:0]         frac_o
);
  logic [W-1:0]         fsum;
  logic [W-1:0]         fdif;
  logic                 carry_gated;
  logic                 borrow;
  logic signed [EW+1:0] sa;
  logic signed [EW+1:0] sb;
  logic signed [EW+1:0] cin;

  always_comb begin
    // Fraction adder and fraction subtractor.
    fsum   = {1'b0, fa_i} + {1'b0, fb_i};
    fdif   = {1'b0, fa_i} - {1'b0, fb_i};
    borrow = fdif[W-1];
    // R3: carry reaches the exponent only when multiplying.
    carry_gated = fsum[W-1] & ~div_i;
    sa = signed'({2'b00, ka_i});
    sb = signed'({2'b00, kb_i});
    cin = '0;
    if (div_i && borrow)  cin = '1;
    else if (carry_gated) cin = (EW+2)'(1);
    // Exponent unit.
    exp_o  = div_i ? (sa - sb + cin) : (sa + sb + cin);
    // R4: on borrow the wrapped difference already equals 1 + m1 - m2.
    frac_o = div_i ? fdif[W-2:0] : fsum[W-2:0];
  end
endmodule

// File: rtl/ald_antilog.sv
module ald_antilog #(
  parameter int W  = 16,
  parameter int EW = $clog2(W),
  parameter int RW = 2 * W
) (
  input  logic                 div_i,
  input  logic signed [EW+1:0] exp_i,
  input  logic [W-2:0]         frac_i,
  output logic [RW-1:0]        res_o
);
  logic [W-1:0]         mant;
  logic signed [EW+1:0] qsh;
  logic [EW+1:0]        rsh;

  always_comb begin
    mant  = {1'b1, frac_i};
    qsh   = exp_i + (EW+2)'(1);
    rsh   = '0;
    res_o = '0;
    if (!div_i) begin
      // Product: leading one at bit exp, W-1 fraction bits truncated.
      res_o = RW'(({{RW{1'b0}}, mant} << $unsigned(exp_i)) >> (W - 1));
    end else if (qsh >= 0) begin
      // Quotient with W fraction bits: scale is 2^(exp+1).
      res_o = {{(RW-W){1'b0}}, mant} << $unsigned(qsh);
    end else begin
      rsh   = $unsigned(-qsh);
      res_o = {{(RW-W){1'b0}}, mant} >> rsh;
    end
  end
endmodule

// File: rtl/approx_logmuldiv.sv
module approx_logmuldiv #(
  parameter int W  = 16,
  parameter int EW = $clog2(W),
  parameter int RW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          div_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  output logic [RW-1:0] result_o,
  output logic          done_o,
  output logic          dz_o
);
  import ald_pkg::*;

  localparam int NOPS = 2;

  logic rst_q;

  logic [NOPS-1:0][W-1:0]  opnd;
  logic [NOPS-1:0][EW-1:0] cv_k;
  logic [NOPS-1:0][W-2:0]  cv_f;
  logic [NOPS-1:0]         cv_z;

  // Stage 1: logarithms of both operands.
  logic                    s1_v, s1_v_n;
  op_e                     s1_op;
  logic [NOPS-1:0][EW-1:0] s1_k;
  logic [NOPS-1:0][W-2:0]  s1_f;
  logic [NOPS-1:0]         s1_z;

  // Stage 2: combined logarithm.
  logic                    cb_div;
  logic signed [EW+1:0]    cb_exp;
  logic [W-2:0]            cb_frac;
  logic                    s2_v, s2_v_n;
  op_e                     s2_op;
  logic signed [EW+1:0]    s2_exp;
  logic [W-2:0]            s2_frac;
  logic                    s2_zero, s2_zero_n;
  logic                    s2_dz, s2_dz_n;

  // Stage 3: antilog and outputs.
  logic [RW-1:0]           al_res;
  logic [RW-1:0]           res_n;

  ald_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign opnd[0] = opa_i;
  assign opnd[1] = opb_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_conv
    ald_log_conv #(.W(W), .EW(EW)) i_conv (
      .x_i    (opnd[g]),
      .k_o    (cv_k[g]),
      .frac_o (cv_f[g]),
      .zero_o (cv_z[g])
    );
  end

  assign cb_div = (s1_op == OP_DIV);

  ald_combine #(.W(W), .EW(EW)) i_combine (
    .div_i  (cb_div),
    .ka_i   (s1_k[0]),
    .fa_i   (s1_f[0]),
    .kb_i   (s1_k[1]),
    .fb_i   (s1_f[1]),
    .exp_o  (cb_exp),
    .frac_o (cb_frac)
  );

  ald_antilog #(.W(W), .EW(EW), .RW(RW)) i_antilog (
    .div_i  (s2_op == OP_DIV),
    .exp_i  (s2_exp),
    .frac_i (s2_frac),
    .res_o  (al_res)
  );

  // Next-state logic.
  always_comb begin
    s1_v_n    = start_i;
    s2_v_n    = s1_v;
    s2_zero_n = s1_z[0] | s1_z[1];
    s2_dz_n   = cb_div & s1_z[1];
    res_n     = s2_zero ? '0 : al_res;
  end

  // Registers with explicit clock enables.
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_v     <= 1'b0;
      s1_op    <= OP_MUL;
      s1_k     <= '0;
      s1_f     <= '0;
      s1_z     <= '0;
      s2_v     <= 1'b0;
      s2_op    <= OP_MUL;
      s2_exp   <= '0;
      s2_frac  <= '0;
      s2_zero  <= 1'b0;
      s2_dz    <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
      dz_o     <= 1'b0;
    end else begin
      s1_v   <= s1_v_n;
      s2_v   <= s2_v_n;
      done_o <= s2_v;
      if (start_i) begin
        s1_op <= op_e'(div_i);
        s1_k  <= cv_k;
        s1_f  <= cv_f;
        s1_z  <= cv_z;
      end
      if (s1_v) begin
        s2_op   <= s1_op;
        s2_exp  <= cb_exp;
        s2_frac <= cb_frac;
        s2_zero <= s2_zero_n;
        s2_dz   <= s2_dz_n;
      end
      if (s2_v) begin
        result_o <= res_n;
        dz_o     <= s2_dz;
      end
    end
  end

  // R10: each start gives exactly one done pulse, LATENCY cycles later.
  p_done_latency_r10: assert property (@(posedge clk) disable iff (!rst_q)
    done_o == $past(start_i, 3))
    else $error("done pulse not aligned to start");

  // R7: a divide-by-zero result reads as zero.
  p_dz_zero_result_r7: assert property (@(posedge clk) disable iff (!rst_q)
    dz_o |-> (result_o == '0))
    else $error("nonzero result with divide-by-zero flag");

  // R7: the flag reports exactly a zero divisor in divide mode.
  p_dz_source_r7: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> (dz_o == ($past(div_i, 3) && ($past(opb_i, 3) == '0))))
    else $error("divide-by-zero flag mismatch");

  // R9: the approximate product never exceeds the exact product.
  p_mul_no_overshoot_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (done_o && !$past(div_i, 3)) |->
      (result_o <= ({{(RW-W){1'b0}}, $past(opa_i, 3)} * {{(RW-W){1'b0}}, $past(opb_i, 3)})))
    else $error("approximate product above exact product");
endmodule

// File: tb/test_approx_logmuldiv.sv
module test_approx_logmuldiv;
  localparam int WB = 16;
  localparam int WS = 6;

  logic clk;
  logic rst_n;

  logic            start_b, div_b;
  logic [WB-1:0]   a_b, b_b;
  logic [2*WB-1:0] res_b;
  logic            done_b, dz_b;

  logic            start_s, div_s;
  logic [WS-1:0]   a_s, b_s;
  logic [2*WS-1:0] res_s;
  logic            done_s, dz_s;

  int checks;
  int failures;
  bit finished;

  approx_logmuldiv #(.W(WB)) i_approx_logmuldiv (
    .clk (clk), .rst_n (rst_n), .start_i (start_b), .div_i (div_b),
    .opa_i (a_b), .opb_i (b_b), .result_o (res_b), .done_o (done_b), .dz_o (dz_b)
  );

  approx_logmuldiv #(.W(WS)) i_approx_logmuldiv_small (
    .clk (clk), .rst_n (rst_n), .start_i (start_s), .div_i (div_s),
    .opa_i (a_s), .opb_i (b_s), .result_o (res_s), .done_o (done_s), .dz_o (dz_s)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int top_bit(input longint x);
    int k = 0;
    for (int i = 0; i < 48; i++) if (x[i]) k = i;
    return k;
  endfunction

  // Arithmetic model taken from the requirement text.
  function automatic longint model(input int w, input longint a, input longint b, input bit dv);
    longint half, fa, fb, d, mant;
    int ka, kb, e, sh;
    if (a == 0 || b == 0) return 0;
    half = longint'(1) << (w - 1);
    ka = top_bit(a);
    kb = top_bit(b);
    fa = (a - (longint'(1) << ka)) << (w - 1 - ka);
    fb = (b - (longint'(1) << kb)) << (w - 1 - kb);
    if (!dv) begin
      d = fa + fb;
      e = ka + kb;
      if (d >= half) begin e++; d -= half; end
      return ((half + d) << e) >> (w - 1);
    end
    d = fa - fb;
    e = ka - kb;
    if (d < 0) begin e--; d += half; end
    mant = half + d;
    sh = e + 1;
    if (sh >= 0) return mant << sh;
    return mant >> (-sh);
  endfunction

  task automatic run_big(input longint a, input longint b, input bit dv,
                         output longint r, output bit dz);
    @(negedge clk);
    a_b = WB'(a); b_b = WB'(b); div_b = dv; start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "done after three cycles", longint'(done_b), 1);
    r = longint'(res_b);
    dz = dz_b;
  endtask

  task automatic run_small(input longint a, input longint b, input bit dv,
                           output longint r, output bit dz);
    @(negedge clk);
    a_s = WS'(a); b_s = WS'(b); div_s = dv; start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0;
    repeat (2) @(negedge clk);
    r = done_s ? longint'(res_s) : -1;
    dz = dz_s;
  endtask

  task automatic big_case(input string rq, input longint a, input longint b,
                          input bit dv, input longint exp);
    longint r;
    bit dz;
    run_big(a, b, dv, r, dz);
    chk(rq, $sformatf("%0h %s %0h", a, dv ? "/" : "*", b), r, exp);
    chk(rq, "divide-by-zero flag", longint'(dz), longint'(dv && b == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint r, ex;
    bit dz;
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0;
    start_b = 1'b0; div_b = 1'b0; a_b = '0; b_b = '0;
    start_s = 1'b0; div_s = 1'b0; a_s = '0; b_s = '0;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", longint'(done_b), 0);
    chk("R1", "result in reset", longint'(res_b), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "done after reset", longint'(done_b), 0);
    chk("R1", "dz after reset", longint'(dz_b), 0);
    chk("R1", "result after reset", longint'(res_b), 0);
    chk("R1", "small result after reset", longint'(res_s), 0);

    // Directed cases on the 16-bit default.
    big_case("R8", 64'h6735, 1, 0, 64'h6735);
    big_case("R8", 64'h6735, 64'h100, 0, 64'h673500);
    big_case("R8", 64'h6735, 4, 1, 64'h19CD4000);
    big_case("R8", 64'hFFFF, 1, 1, 64'hFFFF0000);
    big_case("R5", 1, 64'h8000, 1, 2);
    big_case("R5", 3, 64'hFFFF, 1, model(WB, 3, 64'hFFFF, 1));
    big_case("R3", 3, 3, 0, 8);
    big_case("R3", 7, 7, 0, 48);
    big_case("R3", 7, 5, 1, 64'h18000);
    big_case("R4", 5, 7, 1, 64'hC000);
    big_case("R4", 3, 3, 1, 64'h10000);
    big_case("R2", 64'hFFFF, 64'hFFFF, 0, model(WB, 64'hFFFF, 64'hFFFF, 0));
    big_case("R2", 64'h1234, 64'hABCD, 0, model(WB, 64'h1234, 64'hABCD, 0));
    big_case("R6", 0, 64'h1234, 0, 0);
    big_case("R6", 64'h1234, 0, 0, 0);
    big_case("R6", 0, 5, 1, 0);
    big_case("R7", 64'h1234, 0, 1, 0);
    big_case("R7", 0, 0, 1, 0);
    big_case("R7", 64'h1234, 2, 1, model(WB, 64'h1234, 2, 1));

    // R10: three back-to-back starts give three consecutive done pulses.
    @(negedge clk);
    a_b = 16'd3; b_b = 16'd3; div_b = 1'b0; start_b = 1'b1;
    @(negedge clk);
    a_b = 16'd5; b_b = 16'd7; div_b = 1'b1;
    @(negedge clk);
    chk("R10", "no early done", longint'(done_b), 0);
    a_b = 16'h6735; b_b = 16'd1; div_b = 1'b0;
    @(negedge clk);
    start_b = 1'b0;
    chk("R10", "pulse 1", longint'(done_b), 1);
    chk("R10", "result 1", longint'(res_b), 8);
    @(negedge clk);
    chk("R10", "pulse 2", longint'(done_b), 1);
    chk("R10", "result 2", longint'(res_b), 64'hC000);
    @(negedge clk);
    chk("R10", "pulse 3", longint'(done_b), 1);
    chk("R10", "result 3", longint'(res_b), 64'h6735);
    @(negedge clk);
    chk("R10", "single pulse", longint'(done_b), 0);

    // Exhaustive sweep of the reduced configuration.
    for (int a = 0; a < (1 << WS); a++) begin
      for (int b = 0; b < (1 << WS); b++) begin
        for (int dv = 0; dv < 2; dv++) begin
          run_small(a, b, bit'(dv), r, dz);
          ex = model(WS, a, b, bit'(dv));
          if (dv == 1 && b == 0)      chk("R7", $sformatf("small %0d/0", a), r, 0);
          else if (a == 0 || b == 0)  chk("R6", $sformatf("small %0d,%0d", a, b), r, 0);
          else if (dv == 1)           chk("R4", $sformatf("small %0d/%0d", a, b), r, ex);
          else                        chk("R2", $sformatf("small %0d*%0d", a, b), r, ex);
          chk("R7", "small dz", longint'(dz), longint'(dv == 1 && b == 0));
          if (dv == 0 && a != 0 && b != 0) begin
            chk("R9", "product upper bound", longint'(r <= a * b), 1);
            chk("R9", "product lower bound", longint'(9 * r + 9 >= 8 * a * b), 1);
          end
          if (dv == 0 && (b & (b - 1)) == 0 && b != 0)
            chk("R8", "small exact product", r, longint'(a) * b);
        end
      end
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule